// File: doc/BRIEF.md
# Wavefront Memory Request Coalescer

This block sits between the lanes of a wide lockstep execution unit and its first-level cache. One memory instruction of a wavefront hands it a byte address for every lane together with the execution mask that says which lanes really perform the access. The block folds all active lanes whose addresses land in the same cache block into one downstream request, so the cache sees one request per distinct block instead of one per lane.

Each downstream request carries the aligned block address and a bit-vector naming the lanes it serves. Requests leave one per cycle over a valid/ready handshake, in order of the lowest-numbered active lane that touches each block. The whole wavefront is held until its last block has been handed over: no new wavefront is taken while blocks remain, and a one-cycle completion pulse follows the final transfer. A wavefront with no active lanes produces no request and completes at once.

Top module: `wave_coalescer`

## Requirements
- R1: The block address of a request is the address of the lanes it serves with the low log2(BLOCK_BYTES) bits cleared (BLOCK_BYTES defaults to 64, so bits 5:0 are zero).
- R2: A wavefront produces exactly one request per distinct cache block touched by its active lanes, and no other request.
- R3: Bit i of a request's lane vector is set exactly when lane i is active and its address falls in that request's block.
- R4: A lane whose mask bit is 0 appears in no lane vector and causes no request; an all-zero mask yields no request at all.
- R5: Requests are emitted in increasing order of the lowest active lane number that touches each block.
- R6: While any block of the current wavefront is unsent, in_ready is 0 and a wavefront presented on the input is ignored.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_block and out_lanes hold their values.
- R8: With out_ready held at 1, a wavefront touching N distinct blocks emits them in N consecutive cycles, the first in the cycle after the wavefront is accepted.
- R9: wave_done is a single-cycle pulse in the cycle after the final block transfer, or in the cycle after accepting a wavefront with an all-zero mask.
- R10: After synchronous reset, out_valid is 0, in_ready is 1 and wave_done is 0, whatever was in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A wavefront instruction is presented |
| in_ready | output | 1 | Coalescer is idle and can take a wavefront |
| in_addr | input | LANES*ADDR_W | Lane byte addresses, lane i in bits i*ADDR_W +: ADDR_W |
| in_mask | input | LANES | Execution mask, bit i = lane i active |
| out_valid | output | 1 | A block request is offered |
| out_ready | input | 1 | Downstream accepts the offered request |
| out_block | output | ADDR_W | Aligned block address of the request |
| out_lanes | output | LANES | Lanes served by the request |
| wave_done | output | 1 | One-cycle pulse: all blocks of the wavefront sent |

## Verification
The hardest state to reach is a wavefront arriving while an earlier one still has blocks outstanding, since a well-behaved producer waits on in_ready. The stimulus forces it by raising in_valid with a different address pattern in the first cycle after a multi-block wavefront is accepted, then checks that the emitted sequence is still that of the first wavefront. Order is stressed with a descending-address pattern, so sorting by address instead of by lane number shows up, and backpressure is applied on alternate cycles to catch payloads that drift while stalled.

// File: rtl/coal_pkg.sv
// Shared defaults for the wavefront coalescer.
// Assumes: consumers override these through module parameters where needed.
package coal_pkg;
    localparam int DEF_LANES       = 64;
    localparam int DEF_ADDR_W      = 32;
    localparam int DEF_BLOCK_BYTES = 64;
endpackage

// File: rtl/coal_addr_bank.sv
// Holds the block-aligned address of every lane of the current wavefront.
// Assumes: BLOCK_BYTES is a power of two; load is only raised on acceptance.
module coal_addr_bank #(
    parameter int LANES       = coal_pkg::DEF_LANES,
    parameter int ADDR_W      = coal_pkg::DEF_ADDR_W,
    parameter int BLOCK_BYTES = coal_pkg::DEF_BLOCK_BYTES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [LANES*ADDR_W-1:0] addr_flat,
    output logic [LANES*ADDR_W-1:0] blk_flat
);
    localparam int OFF_W = $clog2(BLOCK_BYTES);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W'(1) << OFF_W) - ADDR_W'(1));

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [ADDR_W-1:0] blk_q;
        // Capture the aligned block address of this lane when a wavefront is taken.
        always_ff @(posedge clk) begin
            if (!rst_n)
                blk_q <= '0;
            else if (load)
                blk_q <= addr_flat[g*ADDR_W +: ADDR_W] & ALIGN_MASK;
        end
        assign blk_flat[g*ADDR_W +: ADDR_W] = blk_q;
    end
endmodule

// File: rtl/coal_lead_pick.sv
// Finds the lowest-numbered lane still waiting for its block to be sent.
// Assumes: pend is a registered vector; output is purely combinational.
module coal_lead_pick #(
    parameter int LANES = coal_pkg::DEF_LANES,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic [LANES-1:0] pend,
    output logic [IDX_W-1:0] lead_idx,
    output logic [LANES-1:0] lead_oh,
    output logic             lead_ok
);
    // Priority scan from the top so the lowest pending lane wins.
    always_comb begin
        lead_idx = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pend[i]) lead_idx = IDX_W'(i);
        end
        lead_ok = |pend;
        lead_oh = lead_ok ? (LANES'(1) << lead_idx) : '0;
    end

    // The selected lane is at most one and always pending (R5).
    always_comb begin
        assert_lead_onehot_R5: assert ($onehot0(lead_oh) && ((lead_oh & ~pend) == '0));
    end
endmodule

// File: rtl/coal_block_match.sv
// Marks every pending lane whose block equals the leader's block.
// Assumes: blk_flat holds aligned addresses, one ADDR_W slice per lane.
module coal_block_match #(
    parameter int LANES  = coal_pkg::DEF_LANES,
    parameter int ADDR_W = coal_pkg::DEF_ADDR_W
) (
    input  logic [LANES*ADDR_W-1:0] blk_flat,
    input  logic [LANES-1:0]        pend,
    input  logic [ADDR_W-1:0]       lead_blk,
    input  logic [LANES-1:0]        lead_oh,
    output logic [LANES-1:0]        hit
);
    for (genvar g = 0; g < LANES; g++) begin : g_cmp
        assign hit[g] = pend[g] && (blk_flat[g*ADDR_W +: ADDR_W] == lead_blk);
    end

    // The leader always belongs to its own group (R3).
    always_comb begin
        assert_hit_has_leader_R3: assert ((lead_oh & ~hit) == '0);
    end
endmodule

// File: rtl/wave_coalescer.sv
// Top: takes one wavefront of lane addresses and emits one request per block.
// Assumes: downstream follows valid/ready; payload is valid only with out_valid.
module wave_coalescer #(
    parameter int LANES       = coal_pkg::DEF_LANES,
    parameter int ADDR_W      = coal_pkg::DEF_ADDR_W,
    parameter int BLOCK_BYTES = coal_pkg::DEF_BLOCK_BYTES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [LANES*ADDR_W-1:0] in_addr,
    input  logic [LANES-1:0]        in_mask,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [ADDR_W-1:0]       out_block,
    output logic [LANES-1:0]        out_lanes,
    output logic                    wave_done
);
    localparam int IDX_W = $clog2(LANES);

    logic [LANES-1:0]        pend_q;
    logic [LANES-1:0]        act_q;
    logic                    done_q;
    logic [LANES*ADDR_W-1:0] blk_flat;
    logic [IDX_W-1:0]        lead_idx;
    logic [LANES-1:0]        lead_oh;
    logic                    lead_ok;
    logic [ADDR_W-1:0]       lead_blk;
    logic [LANES-1:0]        hit;
    logic                    load;
    logic                    fire;

    assign in_ready  = (pend_q == '0);
    assign load      = in_valid && in_ready;
    assign out_valid = lead_ok;
    assign fire      = out_valid && out_ready;
    assign lead_blk  = blk_flat[lead_idx*ADDR_W +: ADDR_W];
    assign out_block = lead_blk;
    assign out_lanes = hit;
    assign wave_done = done_q;

    coal_addr_bank #(.LANES(LANES), .ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES)) bank_i (
        .clk(clk), .rst_n(rst_n), .load(load), .addr_flat(in_addr), .blk_flat(blk_flat)
    );

    coal_lead_pick #(.LANES(LANES)) pick_i (
        .pend(pend_q), .lead_idx(lead_idx), .lead_oh(lead_oh), .lead_ok(lead_ok)
    );

    coal_block_match #(.LANES(LANES), .ADDR_W(ADDR_W)) match_i (
        .blk_flat(blk_flat), .pend(pend_q), .lead_blk(lead_blk), .lead_oh(lead_oh), .hit(hit)
    );

    // Track lanes still waiting: load from mask, retire the served group on each transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else if (load)
            pend_q <= in_mask;
        else if (fire)
            pend_q <= pend_q & ~hit;
    end

    // Remember the active lanes of the wavefront for checking only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_q <= '0;
        else if (load)
            act_q <= in_mask;
    end

    // Completion pulse after the last transfer or after an empty wavefront.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else
            done_q <= (fire && ((pend_q & ~hit) == '0)) || (load && (in_mask == '0));
    end

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_block) && $stable(out_lanes)));

    assert_busy_blocks_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    assert_lanes_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_lanes != '0) && ((out_lanes & ~act_q) == '0)));

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wave_done |-> (!out_valid && in_ready));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wave_done |=> !wave_done);

    assert_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_block[$clog2(BLOCK_BYTES)-1:0] == '0));
endmodule

// File: tb/wave_coalescer_tb_top.sv
module wave_coalescer_tb_top;
    localparam int LANES = 64;
    localparam int AW    = 32;

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] stride;
        logic [7:0]  modv;
        logic [63:0] mask;
        logic        toggle;
        logic        intrude;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{32'h0000_1000, 32'd4,        8'd64, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0},
        '{32'h0000_2000, 32'd64,       8'd64, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1},
        '{32'h0000_3014, 32'd0,        8'd64, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0},
        '{32'h0000_0040, 32'd128,      8'd3,  64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1},
        '{32'h0000_8000, 32'd32,       8'd64, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0, 1'b0},
        '{32'h0000_9000, 32'd4,        8'd64, 64'h0000_0000_0000_0000, 1'b0, 1'b0},
        '{32'h0000_A000, 32'd4,        8'd64, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0},
        '{32'h0001_0000, 32'hFFFF_FFC0, 8'd64, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0},
        '{32'h0000_1030, 32'd8,        8'd64, 64'h0F0F_0000_00FF_F00F, 1'b1, 1'b0},
        '{32'h0000_C000, 32'd16,       8'd64, 64'h8000_0000_0000_0000, 1'b0, 1'b0}
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic                 in_ready;
    logic [LANES*AW-1:0]  in_addr = '0;
    logic [LANES-1:0]     in_mask = '0;
    logic                 out_valid;
    logic                 out_ready = 1'b0;
    logic [AW-1:0]        out_block;
    logic [LANES-1:0]     out_lanes;
    logic                 wave_done;

    int errors = 0;
    int checks = 0;
    int cyc_total = 0;

    logic [31:0] exp_blk [LANES];
    logic [63:0] exp_ln  [LANES];
    int          exp_n;

    always #2.5 clk = ~clk;

    wave_coalescer #(.LANES(LANES), .ADDR_W(AW), .BLOCK_BYTES(64)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_mask(in_mask), .out_valid(out_valid), .out_ready(out_ready),
        .out_block(out_block), .out_lanes(out_lanes), .wave_done(wave_done)
    );

    // Watchdog: an overlong run is one failed check, then the summary.
    always @(posedge clk) begin
        cyc_total <= cyc_total + 1;
        if (cyc_total > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired: actual=%0d expected<=100000 cycles", cyc_total);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lane_addr(input vec_t v, input int l);
        return v.base + 32'(l % int'(v.modv)) * v.stride;
    endfunction

    // Reference model: distinct blocks in order of first active lane.
    task automatic build_expect(input vec_t v);
        exp_n = 0;
        for (int l = 0; l < LANES; l++) begin
            if (v.mask[l]) begin
                logic [31:0] b;
                bit found;
                b = lane_addr(v, l) & 32'hFFFF_FFC0;
                found = 0;
                for (int k = 0; k < exp_n; k++) begin
                    if (exp_blk[k] == b) begin
                        exp_ln[k][l] = 1'b1;
                        found = 1;
                    end
                end
                if (!found) begin
                    exp_blk[exp_n] = b;
                    exp_ln[exp_n] = 64'd1 << l;
                    exp_n++;
                end
            end
        end
    endtask

    task automatic run_wave(input vec_t v);
        int k = 0;
        int done_cnt = 0;
        int done_cyc = -1;
        int last_fire = -1;
        bit held = 0;
        logic [31:0] hb;
        logic [63:0] hl;
        build_expect(v);
        @(negedge clk);
        chk(in_ready === 1'b1, "R6 idle in_ready", {63'd0, in_ready}, 64'd1);
        in_valid = 1'b1;
        in_mask = v.mask;
        for (int l = 0; l < LANES; l++) in_addr[l*AW +: AW] = lane_addr(v, l);
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            in_valid = 1'b0;
            if (v.intrude && c == 0) begin
                in_valid = 1'b1;
                in_mask = '1;
                for (int l = 0; l < LANES; l++) in_addr[l*AW +: AW] = 32'hFFFF_0000 + 32'(l);
            end
            out_ready = v.toggle ? c[0] : 1'b1;
            #1;
            if (held) begin
                chk(out_valid && out_block == hb && out_lanes == hl, "R7 hold while stalled",
                    {32'd0, out_block}, {32'd0, hb});
                held = 0;
            end
            if (out_valid) begin
                chk(in_ready === 1'b0, "R6 busy in_ready", {63'd0, in_ready}, 64'd0);
                if (!out_ready) begin
                    held = 1; hb = out_block; hl = out_lanes;
                end else begin
                    if (k < exp_n) begin
                        chk(out_block == exp_blk[k], "R1/R5 block address and order",
                            {32'd0, out_block}, {32'd0, exp_blk[k]});
                        chk(out_lanes == exp_ln[k], "R3 lane vector", out_lanes, exp_ln[k]);
                        chk((out_lanes & ~v.mask) == '0, "R4 inactive lanes", out_lanes, v.mask);
                    end else begin
                        chk(0, "R2 extra request", 64'(k + 1), 64'(exp_n));
                    end
                    if (!v.toggle)
                        chk(c == k, "R8 one block per cycle", 64'(c), 64'(k));
                    k++;
                    last_fire = c;
                end
            end
            if (wave_done) begin
                done_cnt++;
                if (done_cyc < 0) done_cyc = c;
            end
            if (done_cyc >= 0 && c > done_cyc + 2) break;
        end
        in_valid = 1'b0;
        chk(k == exp_n, "R2 request count", 64'(k), 64'(exp_n));
        chk(done_cnt == 1 && done_cyc == last_fire + 1, "R9 done pulse timing",
            64'(done_cyc), 64'(last_fire + 1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!out_valid && in_ready && !wave_done, "R10 reset state",
            {61'd0, out_valid, in_ready, wave_done}, 64'b010);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_wave(TBL[i]);

        // R4: empty wavefront gives no request and completes in one cycle (covered in table row 6).
        // R10: reset in the middle of a wavefront clears everything.
        @(negedge clk);
        in_valid = 1'b1;
        in_mask = '1;
        for (int l = 0; l < LANES; l++) in_addr[l*AW +: AW] = 32'h0004_0000 + 32'(l * 64);
        out_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk(out_valid === 1'b1, "R10 pre-reset busy", {63'd0, out_valid}, 64'd1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk(!out_valid && in_ready && !wave_done, "R10 reset mid-wave",
            {61'd0, out_valid, in_ready, wave_done}, 64'b010);
        rst_n = 1'b1;

        // R8: after reset a fresh wavefront runs normally.
        run_wave(TBL[0]);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule